// File: doc/BRIEF.md
# Buffered Timer/Counter with Prescaler

This block is a small register-mapped timer that counts either a periodic tick derived from the system clock (one tick every four clocks) or the edges of an external input pin. A programmable power-of-two prescaler may be placed in front of the count register. The count is 8 or 16 bits wide. Rolling over sets a sticky overflow flag, which software clears.

Software reaches the block through single-cycle read and write strobes with a 2-bit address and a byte of data. The bus has no back-pressure: every strobe is accepted in the cycle it is presented, and read data is returned combinationally in that same cycle. For 16-bit use, the upper count byte is reached only through a buffer register. A read of the low byte takes a snapshot of the live upper byte into that buffer. A write of the low byte loads the buffered value into the live upper byte. Both 16-bit reads and 16-bit writes are therefore atomic, even across a carry. After any write to the count, the next two ticks produce no increment.

The register map is at byte addresses. Address 0 is control, address 1 is the low count byte, address 2 is the upper-byte buffer, and address 3 is status, with the flag in bit 0.

Top module: `bufd_timer`

## Requirements
- R1: After reset, control reads 0xB7 and the low byte, the buffer and status all read 0. The control bits are: bit7 run, bit6 wide (1 = 16-bit), bit5 external source, bit4 falling edge, bit3 prescaler bypass, and bits2:0 ratio code. The reset value therefore means running, 8-bit, external source, falling edge, prescaler in use, ratio code 7.
- R2: With bit5 = 0, the source event is an internal tick that occurs once every four system clocks.
- R3: With bit5 = 1, the source event is a rising edge of the external pin when bit4 = 0, or a falling edge when bit4 = 1. Edges of the other polarity are ignored.
- R4: The external pin passes through a two-stage synchronizer and an edge detector. A level first sampled at clock edge A changes the count at edge A+2.
- R5: A write to address 1 discards source events until two internal ticks have passed after the write edge, so exactly two ticks are lost. A write in the same cycle as an increment takes priority over the increment.
- R6: When bit3 = 0, the count advances once per 2^(n+1) source events, where n = bits2:0 (ratios 1:2 to 1:256). When bit3 = 1, the count advances on every event. A write to address 1 clears the prescaler.
- R7: Status bit0 is set when the count rolls over: 0xFF to 0x00 in 8-bit mode, or 0xFFFF to 0x0000 in 16-bit mode. It is cleared only by writing status with bit0 = 0. Writing 1 has no effect, and if a set and a clear fall in the same cycle, the set wins.
- R8: In 16-bit mode, a read of address 1 copies the live upper byte into the buffer in that cycle.
- R9: A write to address 2 only loads the buffer. A write to address 1 loads the low byte, and in 16-bit mode it also loads the live upper byte from the buffer. In 8-bit mode the upper byte is not touched.
- R10: While bit7 = 0, no source event reaches the prescaler or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External count pin, asynchronous |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle (0 when idle) |
| ovf_flag | output | 1 | Sticky overflow flag (status bit0) |

## Verification
The bound checker verifies on every cycle the following:
- low-byte write loading;
- the commit of the buffer into the upper byte on a low-byte write;
- the upper byte staying unchanged when only the buffer is written;
- the snapshot taken on a low-byte read;
- the absence of an increment right after a count write or while stopped;
- the rule that the flag only falls after a write of 0.

Other properties stretch over many cycles and are shown only by the bench's scenarios, which compare against a cyclewise reference model:
- exact tick spacing;
- the count of exactly two lost increments;
- edge polarity;
- synchronizer latency;
- every prescaler ratio;
- reads that stay consistent across a carry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 8;
  localparam int RATIO_W = 3;

  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_LO   = 2'd1,
    REG_HBUF = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic               run;
    logic               wide;
    logic               ext_src;
    logic               fall_edge;
    logic               no_pre;
    logic [RATIO_W-1:0] ratio;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{run: 1'b1, wide: 1'b0, ext_src: 1'b1,
                                 fall_edge: 1'b1, no_pre: 1'b0, ratio: 3'd7};
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic ext_src,
  input  logic fall_edge,
  output logic cyc_tick,
  output logic src_evt
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]       div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   settled;
  logic                   rose;
  logic                   fell;

  // free-running instruction-cycle divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
  assign cyc_tick = (div_q == DIV_LAST);

  // synchronizer chain followed by one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= ext_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= settled;
    end
  end

  assign settled = sync_q[SYNC_STAGES-1];
  assign rose    = settled & ~last_q;
  assign fell    = ~settled & last_q;
  assign src_evt = ext_src ? (fall_edge ? fell : rose) : cyc_tick;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               clear,
  output logic               inc
);
  localparam int PRE_W = 1 << RATIO_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // ratio code n keeps the low n+1 bits: divide by 2^(n+1)
  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(ratio));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (clear)          pre_q <= '0;
    else if (evt && !bypass) pre_q <= pre_q + 1'b1;
  end

  assign inc = evt && (bypass || ((pre_q & mask) == mask));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int DATA_W        = 8,
  parameter int INHIBIT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              cyc_tick,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hbuf,
  input  logic              rd_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_lo,
  output logic [DATA_W-1:0] cnt_hi,
  output logic [DATA_W-1:0] hbuf,
  output logic              rollover,
  output logic              blocked
);
  localparam int INH_W = $clog2(INHIBIT_TICKS + 1);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [INH_W-1:0] inh_q;

  // ticks left in the post-write blackout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   inh_q <= '0;
    else if (wr_lo)               inh_q <= INH_W'(INHIBIT_TICKS);
    else if (cyc_tick && blocked) inh_q <= inh_q - 1'b1;
  end
  assign blocked = (inh_q != '0);

  assign rollover = inc && !wr_lo && (cnt_lo == ALL_ONES) &&
                    (!wide || (cnt_hi == ALL_ONES));

  // live count: a software write wins over an increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (wr_lo) begin
      cnt_lo <= wdata;
      if (wide) cnt_hi <= hbuf;
    end else if (inc) begin
      if (wide) {cnt_hi, cnt_lo} <= {cnt_hi, cnt_lo} + 1'b1;
      else      cnt_lo <= cnt_lo + 1'b1;
    end
  end

  // upper-byte buffer: loaded by software or snapshot on a low read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hbuf <= '0;
    else if (wr_hbuf)        hbuf <= wdata;
    else if (rd_lo && wide)  hbuf <= cnt_hi;
  end
endmodule

// File: rtl/bufd_timer.sv
module bufd_timer
  import tmr_pkg::*;
#(
  parameter int TICK_DIV      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int INHIBIT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ovf_flag
);
  ctl_t              ctl_q;
  logic              ovf_q;
  logic              wr_ctl, wr_lo, wr_hbuf, wr_stat, rd_lo;
  logic              cyc_tick, src_evt, gated_evt, inc_evt;
  logic              rollover, blocked;
  logic              run_en, wide_en;
  logic [DATA_W-1:0] cnt_lo, cnt_hi, hbuf;

  assign wr_ctl  = bus_wr && (bus_addr == REG_CTL);
  assign wr_lo   = bus_wr && (bus_addr == REG_LO);
  assign wr_hbuf = bus_wr && (bus_addr == REG_HBUF);
  assign wr_stat = bus_wr && (bus_addr == REG_STAT);
  assign rd_lo   = bus_rd && (bus_addr == REG_LO);
  assign run_en  = ctl_q.run;
  assign wide_en = ctl_q.wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RESET;
    else if (wr_ctl) ctl_q <= ctl_t'(bus_wdata);
  end

  tmr_src_sel #(
    .TICK_DIV    (TICK_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_in    (ext_in),
    .ext_src   (ctl_q.ext_src),
    .fall_edge (ctl_q.fall_edge),
    .cyc_tick  (cyc_tick),
    .src_evt   (src_evt)
  );

  assign gated_evt = src_evt && run_en && !blocked;

  tmr_prescale #(
    .RATIO_W (RATIO_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (gated_evt),
    .bypass (ctl_q.no_pre),
    .ratio  (ctl_q.ratio),
    .clear  (wr_lo),
    .inc    (inc_evt)
  );

  tmr_count_core #(
    .DATA_W        (DATA_W),
    .INHIBIT_TICKS (INHIBIT_TICKS)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide_en),
    .cyc_tick (cyc_tick),
    .inc      (inc_evt),
    .wr_lo    (wr_lo),
    .wr_hbuf  (wr_hbuf),
    .rd_lo    (rd_lo),
    .wdata    (bus_wdata),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .hbuf     (hbuf),
    .rollover (rollover),
    .blocked  (blocked)
  );

  // sticky flag: a rollover beats a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ovf_q <= 1'b0;
    else if (rollover)                  ovf_q <= 1'b1;
    else if (wr_stat && !bus_wdata[0])  ovf_q <= 1'b0;
  end
  assign ovf_flag = ovf_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        REG_CTL:  bus_rdata = ctl_q;
        REG_LO:   bus_rdata = cnt_lo;
        REG_HBUF: bus_rdata = hbuf;
        default:  bus_rdata = {{(DATA_W-1){1'b0}}, ovf_q};
      endcase
    end
  end
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       ovf_flag,
  input logic       run,
  input logic       wide,
  input logic       inc_evt,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic [7:0] hbuf
);
  assert_lo_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> cnt_lo == $past(bus_wdata));

  assert_hi_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && wide) |=> cnt_hi == $past(hbuf));

  assert_hbuf_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !inc_evt) |=> $stable(cnt_hi));

  assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1 && wide && !bus_wr) |=> hbuf == $past(cnt_hi));

  assert_no_inc_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> !inc_evt);

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !wide && cnt_lo == 8'hFF && !(bus_wr && bus_addr == 2'd1)) |=> ovf_flag);

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(bus_wr && bus_addr == 2'd3 && !bus_wdata[0]));

  assert_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !inc_evt);
endmodule

bind bufd_timer tmr_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ovf_flag  (ovf_flag),
  .run       (run_en),
  .wide      (wide_en),
  .inc_evt   (inc_evt),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .hbuf      (hbuf)
);

// File: tb/bufd_timer_tb_top.sv
`timescale 1ns/1ps
module bufd_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bufd_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  // ---------------- reference model, stepped each rising edge ----------------
  int m_phase, m_pre, m_inh, m_lo, m_hi, m_buf, m_ctl, m_ovf;
  int sq[$];

  always @(posedge clk) begin : model_step
    bit tick, rise, fall, ev, go, inc, wlo, whb, wst, wct, rlo, wide;
    int r, full, nbuf;
    if (!rst_n) begin
      m_phase = 0; m_pre = 0; m_inh = 0; m_lo = 0; m_hi = 0; m_buf = 0;
      m_ctl = 'hB7; m_ovf = 0; sq = {0, 0, 0};
    end else begin
      tick = (m_phase == 3);
      rise = (sq[1] == 1) && (sq[2] == 0);
      fall = (sq[1] == 0) && (sq[2] == 1);
      wide = m_ctl[6];
      ev   = m_ctl[5] ? (m_ctl[4] ? fall : rise) : tick;
      go   = ev && m_ctl[7] && (m_inh == 0);
      r    = 2 << (m_ctl & 7);
      inc  = go && (m_ctl[3] || ((m_pre % r) == r - 1));
      wlo  = bus_wr && bus_addr == 2'd1;
      whb  = bus_wr && bus_addr == 2'd2;
      wst  = bus_wr && bus_addr == 2'd3;
      wct  = bus_wr && bus_addr == 2'd0;
      rlo  = bus_rd && bus_addr == 2'd1;
      full = wide ? m_hi * 256 + m_lo : m_lo;
      if (inc && !wlo && full == (wide ? 65535 : 255)) m_ovf = 1;
      else if (wst && !bus_wdata[0]) m_ovf = 0;
      nbuf = whb ? int'(bus_wdata) : ((rlo && wide) ? m_hi : m_buf);
      if (wlo) begin
        if (wide) m_hi = m_buf;
        m_lo = bus_wdata;
      end else if (inc) begin
        if (wide) begin
          full = (full + 1) % 65536;
          m_hi = full / 256;
          m_lo = full % 256;
        end else m_lo = (m_lo + 1) % 256;
      end
      m_buf = nbuf;
      if (wlo) m_pre = 0;
      else if (go && !m_ctl[3]) m_pre = (m_pre + 1) % 256;
      if (wlo) m_inh = 2;
      else if (tick && m_inh > 0) m_inh = m_inh - 1;
      if (wct) m_ctl = bus_wdata;
      m_phase = (m_phase + 1) % 4;
      sq.push_front(int'(ext_in));
      void'(sq.pop_back());
    end
  end

  function automatic int model_reg(int a);
    case (a)
      0: return m_ctl;
      1: return m_lo;
      2: return m_buf;
      default: return m_ovf;
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // flag compared with the model on every clock (R7)
  always @(negedge clk) if (rst_n && !done) check("R7 flag", int'(ovf_flag), m_ovf);

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, string req, output int v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'(a);
    #1 v = int'(bus_rdata);
    check(req, v, model_reg(a));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // combinational look without a strobe edge: no side effect
  task automatic peek(int a, output int v);
    bus_rd = 1'b1; bus_addr = 2'(a);
    #1 v = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_read(0, "R1 ctl", v);  check("R1 ctl", v, 'hB7);
    bus_read(1, "R1 lo", v);   check("R1 lo", v, 0);
    bus_read(2, "R1 buf", v);  check("R1 buf", v, 0);
    bus_read(3, "R1 stat", v); check("R1 stat", v, 0);

    // R2 / R5: internal tick, bypass, 24 edges -> 6 ticks, 2 lost
    bus_write(0, 'h88);
    bus_write(1, 'h10);
    repeat (24) @(posedge clk);
    bus_read(1, "R2 R5 lo", v); check("R5 two lost", v, 'h14);

    // R10 stopped
    bus_write(0, 'h08);
    bus_write(1, 'h33);
    repeat (40) @(posedge clk);
    bus_read(1, "R10 lo", v); check("R10 held", v, 'h33);

    // R7 8-bit rollover, clear rules
    bus_write(0, 'h88);
    bus_write(1, 'hFE);
    repeat (16) @(posedge clk);
    bus_read(1, "R7 lo", v); check("R7 wrapped", v, 0);
    check("R7 set8", int'(ovf_flag), 1);
    bus_write(3, 'h01);
    check("R7 write1 keeps", int'(ovf_flag), 1);
    bus_write(3, 'h00);
    check("R7 cleared", int'(ovf_flag), 0);

    // R9 / R8 16-bit deferred write and snapshot
    bus_write(0, 'hC8);
    bus_write(2, 'h01);
    bus_write(1, 'hFD);
    bus_write(2, 'h77);
    bus_read(1, "R8 lo", v);
    bus_read(2, "R9 buf", v); check("R9 deferred", v, 'h01);

    // R8 atomic read across carry
    bus_write(2, 'h01);
    bus_write(1, 'hFE);
    repeat (12) @(posedge clk);
    bus_read(1, "R8 lo", v); check("R8 lo before carry", v, 'hFF);
    repeat (8) @(posedge clk);
    bus_read(2, "R8 buf", v); check("R8 consistent hi", v, 'h01);
    bus_read(1, "R8 lo2", v);
    bus_read(2, "R8 live hi", v); check("R8 carried hi", v, 'h02);

    // R7 16-bit rollover
    bus_write(2, 'hFF);
    bus_write(1, 'hFE);
    repeat (16) @(posedge clk);
    check("R7 set16", int'(ovf_flag), 1);
    bus_read(1, "R7 lo16", v);
    bus_read(2, "R7 hi16", v); check("R7 hi wrapped", v, 0);
    bus_write(3, 'h00);

    // R3 rising edges
    bus_write(0, 'hA8);
    bus_write(1, 'h00);
    repeat (12) @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) ext_in = 1'b1;
      repeat (4) @(negedge clk);
      ext_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(posedge clk);
    bus_read(1, "R3 rise", v); check("R3 rising count", v, 5);

    // R4 latency: level sampled at edge A shows at A+2
    @(negedge clk) ext_in = 1'b1;
    @(posedge clk); @(negedge clk); peek(1, v); check("R4 A", v, 5);
    @(posedge clk); @(negedge clk); peek(1, v); check("R4 A+1", v, 5);
    @(posedge clk); @(negedge clk); peek(1, v); check("R4 A+2", v, 6);
    ext_in = 1'b0;
    repeat (6) @(posedge clk);
    bus_read(1, "R3 falling ignored", v); check("R3 falling ignored", v, 6);

    // R3 falling edges
    bus_write(0, 'hB8);
    bus_write(1, 'h00);
    repeat (12) @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) ext_in = 1'b1;
      repeat (4) @(negedge clk);
      ext_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(posedge clk);
    bus_read(1, "R3 fall", v); check("R3 falling count", v, 5);

    // R6 every prescaler ratio: 2 lost ticks then 3 full periods
    for (int n = 0; n < 8; n++) begin
      bus_write(0, 'h80 | n);
      bus_write(1, 'h00);
      repeat (4 * (2 + 3 * (2 << n))) @(posedge clk);
      bus_read(1, "R6 ratio", v); check($sformatf("R6 ratio %0d", n), v, 3);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule